// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous SRAM that accepts a read or a write command on every enabled clock edge, in any mix, with no idle cycles between them. Every command input is registered on the rising edge. A command passes through two slot registers. A read lands in an output register two enabled edges after its address. A write takes its data from the input bus two enabled edges after its address. That data then waits in a late-write holding register. It is committed to the array when the next accepted write arrives.

Reads always see the newest data. When a read address matches the held write, the held bytes are merged into the array word lane by lane. A two-bit burst counter lets one loaded address continue as a four-beat burst in linear or interleaved order. Other controls provide a clock enable that freezes the pipeline, an asynchronous output enable, and a sleep input that blanks the outputs while the array contents are kept.

The data bus is split into a write-data input and a read-data output with a drive-enable flag. An external pad ring turns that flag into a tri-state driver.

Top module: `zt_pipe_sram`

## Requirements
- R1: A load edge (load_n_i low) starts an access only when ce_a_n_i=0, ce_b_n_i=0 and ce_c_i=1. Any other combination is a deselect: the array is not changed, and drive_o is low for the slot that edge would have produced.
- R2: With oe_n_i low, read data for an address loaded on enabled edge N is on rdata_o with drive_o high after enabled edge N+2.
- R3: For a write loaded on enabled edge N, wdata_i is sampled on enabled edge N+2. be_n_i[i] (active low) is captured with the address and enables lane bits [8i+7:8i].
- R4: A write whose four be_n_i bits are all high is an abort. No array word changes, and drive_o stays low for that slot.
- R5: On an advance edge (load_n_i high) after an active load, wr_n_i and the chip enables are ignored and the same command type continues. The low two address bits step from the loaded base as (base+k) mod 4 when order_il_i=0, or as base XOR k when order_il_i=1. The upper bits stay fixed.
- R6: An advance edge while deselected stays deselected, and drive_o stays low.
- R7: When clk_en_n_i is high, the edge is ignored: no command is taken, no write is done, and rdata_o and drive_o hold their values.
- R8: drive_o is low for write and abort slots whatever oe_n_i is. oe_n_i high forces drive_o low at once, without a clock edge.
- R9: A read returns the newest data for its address, including data still held in the late-write register and merged byte by byte with the array.
- R10: While sleep_i is high, drive_o is low and all other inputs are ignored. In-flight commands are dropped, and the array and held write data are kept.
- R11: After reset, drive_o is low and every array word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Sleep request, active high |
| clk_en_n_i | input | 1 | Clock enable, active low |
| load_n_i | input | 1 | Low loads a new address, high advances the burst |
| wr_n_i | input | 1 | Low selects write on a load edge |
| ce_a_n_i | input | 1 | Chip enable, active low |
| ce_b_n_i | input | 1 | Chip enable, active low |
| ce_c_i | input | 1 | Chip enable, active high |
| order_il_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr_i | input | AW | Word address |
| be_n_i | input | NB | Byte-lane write enables, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | NB*LW | Write data |
| rdata_o | output | NB*LW | Registered read data |
| drive_o | output | 1 | High when rdata_o should be driven onto the bus |

## Verification
If a slot register or the burst counter holds a wrong value, the fault shows on rdata_o or drive_o exactly two enabled edges after the affected load: a wrong word, a driven write slot, or a missing read. A fault in the late-write register stays hidden until a read of the same address arrives, or until the next write commits it. For that reason the random traffic uses a small address space, so that reads hit held data within a few cycles. Stalls are mixed into bursts and forwarding windows, so a missing freeze moves the expected output by one slot, and the fault is seen on the very next check.

// File: rtl/zt_pipe_pkg.sv
package zt_pipe_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    localparam int BURST_W = 2;

    // Low address bits of burst beat `step` starting from `base`.
    function automatic logic [BURST_W-1:0] burst_lsb(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] step,
        input logic               il
    );
        return il ? (base ^ step) : (base + step);
    endfunction

    function automatic logic chips_on(input logic a_n, input logic b_n, input logic c);
        return !a_n && !b_n && c;
    endfunction

endpackage

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe
    import zt_pipe_pkg::*;
#(
    parameter int AW = 5,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go_i,
    input  logic          sleep_i,
    input  logic          load_n_i,
    input  logic          wr_n_i,
    input  logic          ce_a_n_i,
    input  logic          ce_b_n_i,
    input  logic          ce_c_i,
    input  logic          order_il_i,
    input  logic [AW-1:0] addr_i,
    input  logic [NB-1:0] be_n_i,
    output op_e           s2_op_o,
    output logic [AW-1:0] s2_addr_o,
    output logic [NB-1:0] s2_be_o
);
    localparam int HI_W = AW - BURST_W;

    op_e                s1_op;
    logic [AW-1:0]      s1_base;
    logic [BURST_W-1:0] s1_cnt;
    logic [NB-1:0]      s1_be;
    logic [AW-1:0]      s1_addr;
    logic               sel;

    assign sel     = chips_on(ce_a_n_i, ce_b_n_i, ce_c_i);
    assign s1_addr = {s1_base[AW-1 -: HI_W], burst_lsb(s1_base[BURST_W-1:0], s1_cnt, order_il_i)};

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_op     <= OP_IDLE;
            s1_base   <= '0;
            s1_cnt    <= '0;
            s1_be     <= '0;
            s2_op_o   <= OP_IDLE;
            s2_addr_o <= '0;
            s2_be_o   <= '0;
        end else if (sleep_i) begin
            s1_op   <= OP_IDLE;
            s2_op_o <= OP_IDLE;
        end else if (go_i) begin
            s2_op_o   <= s1_op;
            s2_addr_o <= s1_addr;
            s2_be_o   <= s1_be;
            s1_be     <= ~be_n_i;
            if (!load_n_i) begin
                s1_op   <= sel ? (wr_n_i ? OP_READ : OP_WRITE) : OP_IDLE;
                s1_base <= addr_i;
                s1_cnt  <= '0;
            end else begin
                s1_cnt <= s1_cnt + 1'b1;
            end
        end
    end

    p_stall_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        (!go_i && !sleep_i) |=> ($stable(s1_op) && $stable(s1_cnt) && $stable(s2_op_o) && $stable(s2_addr_o)));

    p_deselect_r1: assert property (@(posedge clk) disable iff (rst)
        (go_i && !load_n_i && !sel) |=> (s1_op == OP_IDLE));

    p_advance_keeps_op_r5: assert property (@(posedge clk) disable iff (rst)
        (go_i && load_n_i) |=> (s1_op == $past(s1_op)));

    p_sleep_flush_r10: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> (s1_op == OP_IDLE && s2_op_o == OP_IDLE));

endmodule

// File: rtl/zt_late_write.sv
module zt_late_write
    import zt_pipe_pkg::*;
#(
    parameter int AW = 5,
    parameter int NB = 4,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  op_e              s2_op_i,
    input  logic [AW-1:0]    s2_addr_i,
    input  logic [NB-1:0]    s2_be_i,
    input  logic [NB*LW-1:0] wdata_i,
    output logic [NB*LW-1:0] rd_data_o
);
    localparam int DW    = NB * LW;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          pend_v;
    logic [AW-1:0] pend_addr;
    logic [NB-1:0] pend_be;
    logic [DW-1:0] pend_data;
    logic          take;
    logic          hit;

    assign take = go_i && (s2_op_i == OP_WRITE) && (|s2_be_i);
    assign hit  = pend_v && (pend_addr == s2_addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_addr <= '0;
            pend_be   <= '0;
            pend_data <= '0;
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else if (take) begin
            if (pend_v) begin
                for (int l = 0; l < NB; l++)
                    if (pend_be[l]) mem[pend_addr][l*LW +: LW] <= pend_data[l*LW +: LW];
            end
            pend_v    <= 1'b1;
            pend_addr <= s2_addr_i;
            pend_be   <= s2_be_i;
            pend_data <= wdata_i;
        end
    end

    // Per-lane forwarding of held write data over the array word.
    for (genvar l = 0; l < NB; l++) begin : g_lane
        assign rd_data_o[l*LW +: LW] = (hit && pend_be[l]) ? pend_data[l*LW +: LW]
                                                           : mem[s2_addr_i][l*LW +: LW];
    end

    p_abort_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (go_i && s2_op_i == OP_WRITE && s2_be_i == '0) |=>
            ($stable(pend_v) && $stable(pend_addr) && $stable(pend_data) && $stable(pend_be)));

    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        take |=> (pend_v && pend_data == $past(wdata_i) && pend_addr == $past(s2_addr_i)));

endmodule

// File: rtl/zt_out_stage.sv
module zt_out_stage
    import zt_pipe_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go_i,
    input  logic          sleep_i,
    input  logic          oe_n_i,
    input  op_e           s2_op_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [DW-1:0] rdata_o,
    output logic          drive_o
);
    logic valid_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
            valid_r <= 1'b0;
        end else if (sleep_i) begin
            valid_r <= 1'b0;
        end else if (go_i) begin
            valid_r <= (s2_op_i == OP_READ);
            if (s2_op_i == OP_READ) rdata_o <= rd_data_i;
        end
    end

    assign drive_o = valid_r && !oe_n_i && !sleep_i;

    p_read_valid_r2: assert property (@(posedge clk) disable iff (rst)
        (go_i && s2_op_i == OP_READ) |=> valid_r);

    p_write_blank_r8: assert property (@(posedge clk) disable iff (rst)
        (go_i && s2_op_i != OP_READ) |=> !valid_r);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !go_i |=> $stable(rdata_o));

endmodule

// File: rtl/zt_pipe_sram.sv
module zt_pipe_sram
    import zt_pipe_pkg::*;
#(
    parameter int AW = 5,
    parameter int NB = 4,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_i,
    input  logic             clk_en_n_i,
    input  logic             load_n_i,
    input  logic             wr_n_i,
    input  logic             ce_a_n_i,
    input  logic             ce_b_n_i,
    input  logic             ce_c_i,
    input  logic             order_il_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [NB-1:0]    be_n_i,
    input  logic             oe_n_i,
    input  logic [NB*LW-1:0] wdata_i,
    output logic [NB*LW-1:0] rdata_o,
    output logic             drive_o
);
    localparam int DW = NB * LW;

    logic          go;
    op_e           s2_op;
    logic [AW-1:0] s2_addr;
    logic [NB-1:0] s2_be;
    logic [DW-1:0] rd_data;

    assign go = !clk_en_n_i && !sleep_i;

    zt_cmd_pipe #(.AW(AW), .NB(NB)) u_cmd (
        .clk(clk), .rst(rst), .go_i(go), .sleep_i(sleep_i),
        .load_n_i(load_n_i), .wr_n_i(wr_n_i),
        .ce_a_n_i(ce_a_n_i), .ce_b_n_i(ce_b_n_i), .ce_c_i(ce_c_i),
        .order_il_i(order_il_i), .addr_i(addr_i), .be_n_i(be_n_i),
        .s2_op_o(s2_op), .s2_addr_o(s2_addr), .s2_be_o(s2_be)
    );

    zt_late_write #(.AW(AW), .NB(NB), .LW(LW)) u_lw (
        .clk(clk), .rst(rst), .go_i(go),
        .s2_op_i(s2_op), .s2_addr_i(s2_addr), .s2_be_i(s2_be),
        .wdata_i(wdata_i), .rd_data_o(rd_data)
    );

    zt_out_stage #(.DW(DW)) u_out (
        .clk(clk), .rst(rst), .go_i(go), .sleep_i(sleep_i), .oe_n_i(oe_n_i),
        .s2_op_i(s2_op), .rd_data_i(rd_data),
        .rdata_o(rdata_o), .drive_o(drive_o)
    );

    p_sleep_blank_r10: assert property (@(posedge clk) disable iff (rst)
        $past(sleep_i) && sleep_i |-> !drive_o);

endmodule

// File: tb/zt_pipe_sram_test.sv
module zt_pipe_sram_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep_i = 1'b0, clk_en_n_i = 1'b0, load_n_i = 1'b0, wr_n_i = 1'b1;
    logic        ce_a_n_i = 1'b1, ce_b_n_i = 1'b0, ce_c_i = 1'b1, order_il_i = 1'b0;
    logic [4:0]  addr_i = '0;
    logic [3:0]  be_n_i = '1;
    logic        oe_n_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        drive_o;

    zt_pipe_sram uut (
        .clk(clk), .rst(rst), .sleep_i(sleep_i), .clk_en_n_i(clk_en_n_i),
        .load_n_i(load_n_i), .wr_n_i(wr_n_i), .ce_a_n_i(ce_a_n_i), .ce_b_n_i(ce_b_n_i),
        .ce_c_i(ce_c_i), .order_il_i(order_il_i), .addr_i(addr_i), .be_n_i(be_n_i),
        .oe_n_i(oe_n_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .drive_o(drive_o)
    );

    always #2 clk = ~clk;

    int          tests = 0, fails = 0, ecount = 0;
    bit          mon_on = 1'b0, mon_en, finished = 1'b0;
    logic [31:0] refm [32];
    bit          exp_rd [8];
    logic [31:0] exp_val [8];
    string       exp_tag [8];
    logic [31:0] wsched [8];
    bit          b_active = 1'b0, b_wr = 1'b0;
    logic [4:0]  b_base = '0;
    logic [1:0]  b_cnt = '0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compares each produced slot against the scoreboard entry.
    always @(posedge clk) begin
        mon_en = !clk_en_n_i && !sleep_i;
        #1;
        if (!rst) begin
            if (mon_en) ecount++;
            if (mon_on) begin
                if (exp_rd[ecount % 8] && !oe_n_i)
                    check(drive_o && rdata_o == exp_val[ecount % 8], exp_tag[ecount % 8],
                          drive_o ? rdata_o : 32'hxxxxxxxx, exp_val[ecount % 8]);
                else
                    check(!drive_o, exp_tag[ecount % 8], {31'd0, drive_o}, 32'd0);
            end
        end
    end

    // Driver: one call per clock; computes the expected outcome of its command.
    task automatic issue(input bit stall, input bit ld, input bit wr, input logic [2:0] ce,
                         input logic [4:0] a, input logic [3:0] ben, input bit oen, input string tag);
        int e;
        @(negedge clk);
        e = ecount + 1;
        wdata_i    = wsched[e % 8];
        clk_en_n_i = stall;
        load_n_i   = !ld;
        wr_n_i     = !wr;
        {ce_a_n_i, ce_b_n_i, ce_c_i} = ce;
        addr_i = a;
        be_n_i = ben;
        oe_n_i = oen;
        if (!stall) begin
            int s;
            s = (e + 2) % 8;
            exp_rd[s]  = 1'b0;
            exp_tag[s] = tag;
            if (ld) begin
                if (ce == 3'b001) begin
                    b_active = 1'b1; b_wr = wr; b_base = a; b_cnt = 2'd0;
                end else b_active = 1'b0;
            end else if (b_active) b_cnt = b_cnt + 2'd1;
            if (b_active) begin
                logic [4:0] ea;
                ea = {b_base[4:2], order_il_i ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
                if (b_wr) begin
                    logic [31:0] d;
                    d = $urandom;
                    wsched[s] = d;
                    for (int l = 0; l < 4; l++)
                        if (!ben[l]) refm[ea][l*8 +: 8] = d[l*8 +: 8];
                end else begin
                    exp_rd[s]  = 1'b1;
                    exp_val[s] = refm[ea];
                end
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(0, 1, 0, 3'b101, '0, '1, 0, "R1");
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) refm[i] = '0;
        for (int i = 0; i < 8; i++) begin exp_rd[i] = 0; exp_val[i] = '0; exp_tag[i] = "R11"; wsched[i] = '0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #3;
        check(!drive_o, "R11", {31'd0, drive_o}, 32'd0);
        mon_on = 1'b1;

        // R11: array starts at zero
        issue(0, 1, 0, 3'b001, 5'd7, '1, 0, "R11");
        idle(3);
        // R9: read right after a full write, then after a single-lane write
        issue(0, 1, 1, 3'b001, 5'd4, 4'h0, 0, "R3");
        issue(0, 1, 0, 3'b001, 5'd4, '1, 0, "R9");
        issue(0, 1, 1, 3'b001, 5'd4, 4'hE, 0, "R3");
        issue(0, 1, 0, 3'b001, 5'd4, '1, 0, "R9");
        idle(3);
        // R4: abort write leaves the word unchanged
        issue(0, 1, 1, 3'b001, 5'd4, 4'hF, 0, "R4");
        issue(0, 1, 0, 3'b001, 5'd4, '1, 0, "R4");
        // R1: write with one enable wrong is a deselect
        issue(0, 1, 1, 3'b011, 5'd4, 4'h0, 0, "R1");
        issue(0, 1, 1, 3'b000, 5'd4, 4'h0, 0, "R1");
        issue(0, 1, 1, 3'b101, 5'd4, 4'h0, 0, "R1");
        // R6: continue deselect
        issue(0, 0, 1, 3'b001, 5'd4, 4'h0, 0, "R6");
        issue(0, 1, 0, 3'b001, 5'd4, '1, 0, "R1");
        // R5: linear burst write from base 6, wr_n toggles on advance
        issue(0, 1, 1, 3'b001, 5'd6, 4'h0, 0, "R5");
        issue(0, 0, 0, 3'b110, 5'd0, 4'h0, 0, "R5");
        issue(0, 0, 1, 3'b110, 5'd0, 4'h0, 0, "R5");
        issue(0, 0, 0, 3'b110, 5'd0, 4'h0, 0, "R5");
        // R7: stalls inside a burst read with junk inputs
        issue(0, 1, 0, 3'b001, 5'd5, '1, 0, "R5");
        issue(1, 1, 1, 3'b001, 5'd9, 4'h0, 0, "R7");
        issue(0, 0, 1, 3'b001, 5'd0, 4'h0, 0, "R5");
        issue(1, 1, 1, 3'b001, 5'd9, 4'h0, 0, "R7");
        issue(1, 1, 1, 3'b001, 5'd9, 4'h0, 0, "R7");
        issue(0, 0, 1, 3'b001, 5'd0, 4'h0, 0, "R5");
        issue(0, 0, 0, 3'b001, 5'd0, 4'h0, 1, "R8");
        idle(3);
        // R5: interleaved burst read
        order_il_i = 1'b1;
        issue(0, 1, 0, 3'b001, 5'd6, '1, 0, "R5");
        for (int i = 0; i < 3; i++) issue(0, 0, 1, 3'b000, 5'd0, '0, 0, "R5");
        idle(3);

        // R10: sleep with junk write to a known word
        mon_on = 1'b0;
        @(negedge clk);
        sleep_i = 1'b1; load_n_i = 0; wr_n_i = 0; {ce_a_n_i, ce_b_n_i, ce_c_i} = 3'b001;
        addr_i = 5'd4; be_n_i = 4'h0; wdata_i = 32'hDEADBEEF; oe_n_i = 0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            check(!drive_o, "R10", {31'd0, drive_o}, 32'd0);
        end
        @(negedge clk);
        sleep_i = 1'b0;
        load_n_i = 0; {ce_a_n_i, ce_b_n_i, ce_c_i} = 3'b101;
        for (int i = 0; i < 8; i++) begin exp_rd[i] = 0; exp_tag[i] = "R10"; end
        b_active = 1'b0;
        mon_on = 1'b1;
        issue(0, 1, 0, 3'b001, 5'd4, '1, 0, "R10");
        issue(0, 1, 0, 3'b001, 5'd6, '1, 0, "R10");
        idle(3);

        // Random interleaved traffic in both burst orders
        for (int ph = 0; ph < 2; ph++) begin
            order_il_i = ph[0];
            for (int i = 0; i < 3000; i++) begin
                bit st, ld, wr, oen;
                logic [2:0] ce;
                logic [3:0] ben;
                st  = ($urandom % 100) < 12;
                ld  = !((b_active && ($urandom % 100) < 40) || (!b_active && ($urandom % 100) < 10));
                wr  = $urandom % 2;
                ce  = (($urandom % 100) < 85) ? 3'b001 : 3'($urandom);
                ben = (($urandom % 10) == 0) ? 4'hF : 4'($urandom);
                oen = ($urandom % 10) == 0;
                issue(st, ld, wr, ce, 5'($urandom), ben, oen, wr ? "R3" : "R9");
            end
            idle(4);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule